// File: doc/BRIEF.md
# Oversampling DPLL Bit-Clock Recovery

This block rebuilds the bit timing of a single demodulated line and turns its NRZI-coded level changes into data words. A prescaler outside the block supplies a one-cycle enable, the unit tick. A reloadable down-counter turns these ticks into sampling instants. In fine mode the line is sampled three times per bit at a nominal spacing of four ticks. In coarse mode it is sampled twice per bit at a nominal spacing of six ticks.

Every sample shifts a transition history. The history gains a 1 whenever the new sample differs from the one before it. One sample in each bit period is the decision sample. On that sample the low bits of the history show where the last level change fell. The block then adds or removes one tick from the next sampling interval, which pulls the sampling phase toward the middle of the bit. The decision sample is also NRZI-decoded. The decoded bits are gathered least-significant first into 16-bit words, and each finished word is handed out with a one-cycle valid strobe. A signed counter tracks the net number of phase corrections for diagnostics.

Top module: `dpll_bitclk_rx`

## Requirements
- R1: After reset every output strobe, `bit_o`, `word_o` and `corr_cnt_o` are 0. The interval counter starts so that the first tick after reset is a sampling instant. All outputs are registered: an event caused by a tick shows at the outputs after the clock edge that accepted the tick.
- R2: `samp_o` pulses once per sampling instant. At each instant the interval counter reloads with the chosen interval N, and the next instant is the N-th tick after it.
- R3: At each sampling instant the history shifts left by one. Its bit 0 takes 1 if `line_i` differs from the level taken at the previous instant, which is 0 after reset. Otherwise it takes 0.
- R4: A phase counter advances by one per sampling instant and returns to 0 after its last value: 0,1,2 in fine mode (`coarse_i`=0) and 0,1 in coarse mode (`coarse_i`=1). Phase 0 is the decision sample and is flagged by `dec_o`. The first instant after reset is a decision.
- R5: In fine mode, when the updated history bits [2:0] are 3'b001 on a decision, the next interval is 5 and `late_o` pulses. When they are 3'b100, the next interval is 3 and `early_o` pulses. Any other decision value, and every non-decision sample, gives 4.
- R6: In coarse mode, when the updated history bits [1:0] are 2'b01 on a decision, the next interval is 7 and `late_o` pulses. When they are 2'b10, the next interval is 5 and `early_o` pulses. Any other case gives 6.
- R7: On a decision, the decoded bit `bit_o` is 1 when `line_i` equals the level stored at the previous decision, and 0 otherwise. The stored level starts at 0 and is then replaced by `line_i`.
- R8: Decoded bits fill a 16-bit word with the first bit at bit 0. On the decision that supplies the 16th bit, `word_vld_o` pulses with the word on `word_o`, and collection restarts empty. `word_o` holds its value between words.
- R9: `corr_cnt_o` is a signed 8-bit two's-complement counter that wraps. It rises by one with each `late_o` and falls by one with each `early_o`, and it is unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Interval unit enable from the prescaler |
| coarse_i | input | 1 | 0: three samples per bit, 1: two samples per bit |
| line_i | input | 1 | Demodulated, synchronised line level |
| samp_o | output | 1 | A sampling instant occurred |
| dec_o | output | 1 | That instant was a decision sample |
| bit_o | output | 1 | Last decoded bit |
| late_o | output | 1 | Interval lengthened at this decision |
| early_o | output | 1 | Interval shortened at this decision |
| word_vld_o | output | 1 | `word_o` carries a new word |
| word_o | output | 16 | Last completed word, first bit in bit 0 |
| corr_cnt_o | output | 8 | Signed net correction count |

## Verification
A single decision sample can both apply a phase correction and finish a word. When that happens, `late_o` or `early_o` fires in the same cycle as `word_vld_o`, and the correction counter moves in that same cycle too. The bench provokes this case by driving a random line level with irregular ticks, so transition patterns and word boundaries land on the same decisions many times. Its reference model predicts interval, strobes, word and counter together each cycle. The bench also counts how often correction and word completion coincide and requires that this happens.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_LATE  = 2'd1,
    CORR_EARLY = 2'd2
  } corr_e;

  // Decide the phase correction from the freshly updated history.
  function automatic corr_e classify(input logic coarse, input logic [2:0] h);
    corr_e k;
    k = CORR_NONE;
    if (coarse) begin
      if (h[1:0] == 2'b01)      k = CORR_LATE;
      else if (h[1:0] == 2'b10) k = CORR_EARLY;
    end else begin
      if (h == 3'b001)          k = CORR_LATE;
      else if (h == 3'b100)     k = CORR_EARLY;
    end
    return k;
  endfunction

  // Next interval: nominal widened or narrowed by one unit.
  function automatic int unsigned adjust(input int unsigned nom, input corr_e k);
    int unsigned v;
    v = nom;
    if (k == CORR_LATE)  v = nom + 1;
    if (k == CORR_EARLY) v = nom - 1;
    return v;
  endfunction

endpackage

// File: rtl/dpll_interval_timer.sv
module dpll_interval_timer #(
  parameter int IVW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic [IVW-1:0] reload_i,
  output logic           fire_o
);
  logic [IVW-1:0] cnt_q;

  assign fire_o = tick_i && (cnt_q == IVW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= IVW'(1);
    end else if (tick_i) begin
      cnt_q <= fire_o ? reload_i : cnt_q - IVW'(1);
    end
  end
endmodule

// File: rtl/dpll_phase_detector.sv
module dpll_phase_detector
  import dpll_pkg::*;
#(
  parameter int FINE_NOM   = 4,
  parameter int COARSE_NOM = 6,
  parameter int HIST_W     = 8,
  parameter int CORR_W     = 8,
  parameter int IVW        = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire_i,
  input  logic                     coarse_i,
  input  logic                     line_i,
  output logic                     decide_o,
  output logic                     late_o,
  output logic                     early_o,
  output logic [IVW-1:0]           ivl_o,
  output logic [1:0]               phase_o,
  output logic signed [CORR_W-1:0] corr_o
);
  logic [HIST_W-1:0] hist_q, hist_n;
  logic              prev_q;
  logic [1:0]        phase_q, last_phase;
  corr_e             kind;
  int unsigned       nom;

  assign hist_n     = {hist_q[HIST_W-2:0], line_i ^ prev_q};
  assign last_phase = coarse_i ? 2'd1 : 2'd2;
  assign decide_o   = fire_i && (phase_q == 2'd0);
  assign kind       = decide_o ? classify(coarse_i, hist_n[2:0]) : CORR_NONE;
  assign late_o     = (kind == CORR_LATE);
  assign early_o    = (kind == CORR_EARLY);
  assign nom        = coarse_i ? COARSE_NOM : FINE_NOM;
  assign ivl_o      = IVW'(adjust(nom, kind));
  assign phase_o    = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      prev_q  <= 1'b0;
      phase_q <= 2'd0;
      corr_o  <= '0;
    end else if (fire_i) begin
      hist_q  <= hist_n;
      prev_q  <= line_i;
      phase_q <= (phase_q >= last_phase) ? 2'd0 : phase_q + 2'd1;
      if (late_o)       corr_o <= corr_o + CORR_W'(1);
      else if (early_o) corr_o <= corr_o - CORR_W'(1);
    end
  end
endmodule

// File: rtl/dpll_nrzi_packer.sv
module dpll_nrzi_packer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              line_i,
  output logic              bit_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [WORD_W:0] SENT = {1'b1, {WORD_W{1'b0}}};

  logic            lvl_q;
  logic [WORD_W:0] sh_q, sh_n;

  assign bit_o  = (line_i == lvl_q);
  assign sh_n   = {bit_o, sh_q[WORD_W:1]};
  assign done_o = take_i && sh_n[0];
  assign word_o = sh_n[WORD_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      sh_q  <= SENT;
    end else if (take_i) begin
      lvl_q <= line_i;
      sh_q  <= sh_n[0] ? SENT : sh_n;
    end
  end
endmodule

// File: rtl/dpll_bitclk_rx.sv
module dpll_bitclk_rx #(
  parameter int FINE_NOM   = 4,
  parameter int COARSE_NOM = 6,
  parameter int WORD_W     = 16,
  parameter int CORR_W     = 8,
  parameter int HIST_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic                     coarse_i,
  input  logic                     line_i,
  output logic                     samp_o,
  output logic                     dec_o,
  output logic                     bit_o,
  output logic                     late_o,
  output logic                     early_o,
  output logic                     word_vld_o,
  output logic [WORD_W-1:0]        word_o,
  output logic signed [CORR_W-1:0] corr_cnt_o
);
  localparam int MAX_IV = ((FINE_NOM > COARSE_NOM) ? FINE_NOM : COARSE_NOM) + 1;
  localparam int IVW    = $clog2(MAX_IV + 1);

  logic              fire_w, decide_w, late_w, early_w, bit_w, done_w;
  logic [IVW-1:0]    ivl_w;
  logic [1:0]        phase_w;
  logic [WORD_W-1:0] word_w;

  dpll_interval_timer #(.IVW(IVW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reload_i(ivl_w), .fire_o(fire_w)
  );

  dpll_phase_detector #(
    .FINE_NOM(FINE_NOM), .COARSE_NOM(COARSE_NOM), .HIST_W(HIST_W),
    .CORR_W(CORR_W), .IVW(IVW)
  ) u_pd (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_w), .coarse_i(coarse_i),
    .line_i(line_i), .decide_o(decide_w), .late_o(late_w), .early_o(early_w),
    .ivl_o(ivl_w), .phase_o(phase_w), .corr_o(corr_cnt_o)
  );

  dpll_nrzi_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take_i(decide_w), .line_i(line_i),
    .bit_o(bit_w), .done_o(done_w), .word_o(word_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_o     <= 1'b0;
      dec_o      <= 1'b0;
      bit_o      <= 1'b0;
      late_o     <= 1'b0;
      early_o    <= 1'b0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      samp_o     <= fire_w;
      dec_o      <= decide_w;
      late_o     <= late_w;
      early_o    <= early_w;
      word_vld_o <= done_w;
      if (decide_w) bit_o  <= bit_w;
      if (done_w)   word_o <= word_w;
    end
  end
endmodule

// File: rtl/dpll_bitclk_rx_chk.sv
module dpll_bitclk_rx_chk #(
  parameter int CORR_W = 8,
  parameter int IVW    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              coarse_i,
  input logic              fire_w,
  input logic [IVW-1:0]    ivl_w,
  input logic [1:0]        phase_w,
  input logic              samp_o,
  input logic              dec_o,
  input logic              late_o,
  input logic              early_o,
  input logic              word_vld_o,
  input logic [CORR_W-1:0] corr_cnt_o
);
  // R5
  late_early_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(late_o && early_o));

  // R2
  samp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    samp_o |=> !samp_o);

  // R4
  dec_is_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_o || late_o || early_o) |-> samp_o);

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_w != 2'd3);

  // R5
  fine_ivl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && !coarse_i) |-> (ivl_w >= IVW'(3) && ivl_w <= IVW'(5)));

  // R6
  coarse_ivl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_w && coarse_i) |-> (ivl_w >= IVW'(5) && ivl_w <= IVW'(7)));

  // R8
  word_on_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> dec_o);

  // R9
  corr_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    late_o |-> (corr_cnt_o == $past(corr_cnt_o) + CORR_W'(1)));

  // R9
  corr_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_o |-> (corr_cnt_o == $past(corr_cnt_o) - CORR_W'(1)));

  // R9
  corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!late_o && !early_o) |-> $stable(corr_cnt_o));
endmodule

bind dpll_bitclk_rx dpll_bitclk_rx_chk #(.CORR_W(CORR_W), .IVW(IVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .coarse_i(coarse_i), .fire_w(fire_w),
  .ivl_w(ivl_w), .phase_w(phase_w), .samp_o(samp_o), .dec_o(dec_o),
  .late_o(late_o), .early_o(early_o), .word_vld_o(word_vld_o),
  .corr_cnt_o(corr_cnt_o)
);

// File: tb/tb_dpll_bitclk_rx.sv
module tb_dpll_bitclk_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, coarse_i = 1'b0, line_i = 1'b0;
  logic samp_o, dec_o, bit_o, late_o, early_o, word_vld_o;
  logic [15:0] word_o;
  logic signed [7:0] corr_cnt_o;

  always #2 clk = ~clk;

  dpll_bitclk_rx dut (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // ---------------- behavioural reference ----------------
  int m_cnt, m_hist, m_phase, m_prev, m_lvl;
  bit mq[$];
  logic m_samp, m_dec, m_bit, m_late, m_early, m_wv;
  logic [15:0] m_word;
  logic signed [7:0] m_corr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 1; m_hist = 0; m_phase = 0; m_prev = 0; m_lvl = 0; mq.delete();
      m_samp = 0; m_dec = 0; m_bit = 0; m_late = 0; m_early = 0; m_wv = 0;
      m_word = 0; m_corr = 0;
    end else begin
      m_samp = 0; m_dec = 0; m_late = 0; m_early = 0; m_wv = 0;
      if (tick_i) begin
        if (m_cnt != 1) m_cnt = m_cnt - 1;
        else begin
          int nom, nxt;
          m_samp = 1;
          m_hist = ((m_hist << 1) | ((int'(line_i) != m_prev) ? 1 : 0)) & 255;
          nom = coarse_i ? 6 : 4;
          nxt = nom;
          if (m_phase == 0) begin
            m_dec = 1;
            if (coarse_i) begin
              if ((m_hist % 4) == 1) begin nxt = 7; m_late = 1; end
              if ((m_hist % 4) == 2) begin nxt = 5; m_early = 1; end
            end else begin
              if ((m_hist % 8) == 1) begin nxt = 5; m_late = 1; end
              if ((m_hist % 8) == 4) begin nxt = 3; m_early = 1; end
            end
            if (m_late) m_corr = m_corr + 8'sd1;
            if (m_early) m_corr = m_corr - 8'sd1;
            m_bit = (int'(line_i) == m_lvl);
            m_lvl = int'(line_i);
            mq.push_back(m_bit);
            if (mq.size() == 16) begin
              for (int i = 0; i < 16; i++) m_word[i] = mq[i];
              m_wv = 1;
              mq.delete();
            end
          end
          m_cnt = nxt;
          m_phase = m_phase + 1;
          if (m_phase >= (coarse_i ? 2 : 3)) m_phase = 0;
          m_prev = int'(line_i);
        end
      end
    end
  end

  task automatic fail1(string req, string what, int act, int exp);
    n_bad++;
    $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) fail1(req, what, act, exp);
  endtask

  // per-cycle comparison against the model
  task automatic compare();
    n_cmp++;
    if (samp_o !== m_samp)      fail1("R2", "samp_o", samp_o, m_samp);
    if (dec_o !== m_dec)        fail1("R4", "dec_o", dec_o, m_dec);
    if (late_o !== m_late)      fail1(coarse_i ? "R6 (R3 history)" : "R5 (R3 history)", "late_o", late_o, m_late);
    if (early_o !== m_early)    fail1(coarse_i ? "R6 (R3 history)" : "R5 (R3 history)", "early_o", early_o, m_early);
    if (bit_o !== m_bit)        fail1("R7", "bit_o", bit_o, m_bit);
    if (word_vld_o !== m_wv)    fail1("R8", "word_vld_o", word_vld_o, m_wv);
    if (word_o !== m_word)      fail1("R8", "word_o", word_o, m_word);
    if (corr_cnt_o !== m_corr)  fail1("R9", "corr_cnt_o", corr_cnt_o, m_corr);
  endtask

  // ---------------- stimulus ----------------
  int gmode = 0, tdiv = 1, per = 12000, acc = 0, n_late = 0, n_early = 0, n_both = 0;

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      compare();
      if (late_o) n_late++;
      if (early_o) n_early++;
      if ((late_o || early_o) && word_vld_o) n_both++;
    end
    case (gmode)
      0: tick_i = 1'b1;
      1: tick_i = ((cyc % tdiv) == 0);
      default: tick_i = ($urandom % 3) != 0;
    endcase
    if (gmode == 1) begin
      acc += 1000;
      if (acc >= per) begin
        acc -= per;
        if (($urandom % 4) == 0) line_i = ~line_i;
      end
    end else if (gmode == 2) begin
      line_i = $urandom % 2;
    end
  endtask

  task automatic do_reset(bit crs);
    rst_n = 1'b0; tick_i = 1'b0; line_i = 1'b0; coarse_i = crs; gmode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(int m, int td, int p, int n);
    gmode = m; tdiv = td; per = p; acc = 0;
    repeat (n) step();
  endtask

  // silence after reset: first-tick sample, spacing, all-ones word
  task automatic silence_checks(bit crs, int gap);
    int g;
    @(negedge clk);
    // R1 reset state
    check(samp_o === 0 && word_vld_o === 0 && corr_cnt_o === 0 && word_o === 0 && bit_o === 0,
          "R1", "reset outputs", {samp_o, word_vld_o, bit_o}, 0);
    tick_i = 1'b1;
    @(negedge clk);
    // R1/R4: first tick is a decision sample
    check(samp_o === 1 && dec_o === 1, "R1", "first tick sample", {samp_o, dec_o}, 3);
    check(bit_o === 1, "R7", "equal level decodes 1", bit_o, 1);
    g = 0;
    do begin @(negedge clk); g++; end while (samp_o !== 1 && g < 20);
    check(g == gap, crs ? "R6" : "R5", "nominal sample spacing", g, gap);
    g = 0;
    do begin @(negedge clk); g++; end while (samp_o !== 1 && g < 20);
    check(g == gap, "R2", "second spacing", g, gap);
    g = 0;
    do begin @(negedge clk); g++; end while (word_vld_o !== 1 && g < 400);
    check(word_vld_o === 1 && word_o === 16'hFFFF, "R8", "silence word", word_o, 16'hFFFF);
    check(corr_cnt_o === 0, "R9", "no correction on silence", corr_cnt_o, 0);
  endtask

  initial begin
    do_reset(1'b0);
    silence_checks(1'b0, 4);
    do_reset(1'b0);
    run(1, 1, 12300, 3000);
    run(1, 1, 11700, 3000);
    run(1, 2, 24000, 3000);
    run(2, 1, 0, 3000);
    do_reset(1'b1);
    silence_checks(1'b1, 6);
    do_reset(1'b1);
    run(1, 1, 12300, 3000);
    run(1, 1, 11700, 3000);
    run(2, 1, 0, 3000);
    // R5/R6: both directions of correction occurred
    check(n_late > 0, "R5", "late corrections seen", n_late, 1);
    check(n_early > 0, "R6", "early corrections seen", n_early, 1);
    // R8 with R9: correction and word completion in the same cycle
    check(n_both > 0, "R8", "correction coincident with word", n_both, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule